// File: doc/BRIEF.md
# Dual-Port GPIO Register Bank

This block is the register core of a 16-bit general-purpose I/O expander. The pins form two independent 8-bit ports. Each port has four registers. The direction register decides which pins are driven. The drive-level register sets the level on driven pins. The invert register flips the reported value of chosen bits. The sampled-input register holds the pin value seen at the last read. A serial bus slave sits in front of the block and turns bus transactions into register accesses. Each access carries an index, a one-cycle write strobe with write data, or a one-cycle read strobe. Read data appears on the following cycle.

A single active-low change flag, `irq_n`, tells the host that a pin configured as an input no longer matches the value it last read. Reading a port's sampled-input register captures that port's live pins and ends that port's share of the flag. The pin side gives a drive level and a per-bit output enable for each tri-state pad. It also takes the live pad value back in.

Register index encoding: the index is {kind, port}. The low bit selects port 0 or 1. The upper two bits select the kind: 0 sampled input, 1 drive level, 2 invert, 3 direction. This gives indices 0/1 input, 2/3 drive level, 4/5 invert and 6/7 direction.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the registers read back as follows. Drive level reads 0xFF on both ports. Invert reads 0x00. Direction reads 0xFF. `pin_oe` is all zeros. The sampled-input registers hold 0xFF, so `irq_n` is high while all pins are high.
- R2: A write strobe to a drive-level, invert or direction index replaces only that port's register of that kind. A later read of that index returns the written byte.
- R3: Each `pin_oe` bit is 1 exactly when the matching direction bit is 0. Direction bit 1 means input, and the pad is left undriven.
- R4: Each `pin_out` bit equals the matching drive-level register bit.
- R5: A read strobe on index 0 or 1 returns that port's live pins XOR its invert register on `rd_data` in the next cycle. The other kinds read back unaltered.
- R6: A write strobe to index 0 or 1 changes no register. Because the sampled-input register is unchanged, `irq_n` is unaffected.
- R7: `irq_n` is low whenever a pin whose direction bit is 1 differs from the same bit of its port's sampled-input register. Otherwise it is high.
- R8: A read strobe on index 0 or 1 loads that port's live pins into its sampled-input register. This clears that port's share of the flag but leaves the other port's share as it was.
- R9: Pins whose direction bit is 0 never pull `irq_n` low.
- R10: `rd_data` keeps its value in every cycle without a read strobe, including cycles with a write strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_idx | input | 3 | Register index {kind, port} |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| pin_in | input | 16 | Live pad values, port 1 in the upper byte |
| pin_out | output | 16 | Pad drive levels |
| pin_oe | output | 16 | Pad output enables, 1 drives the pad |
| irq_n | output | 1 | Active-low input-change flag |

## Verification
Every writable index is written with a series of eight different bytes. All six readable registers and both pad buses are compared after each write, which would expose a write landing in the wrong port or the wrong kind.

All 256 values of port 0's pins are read in a sweep. Port 1 carries the complement and each port uses a different invert mask, so a swapped port or a missing XOR shows up as a wrong bit.

The change flag is then driven through a set of cases:
- a single-pin change on one port;
- a capture of the other port, which must not clear the flag;
- a capture of the changed port, which must clear it;
- toggles on pins set as outputs, which must not raise the flag;
- a write to an input index, which must leave the flag alone.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    // Register kind, taken from the upper index bits.
    typedef enum logic [1:0] {
        KIND_IN  = 2'd0,
        KIND_OUT = 2'd1,
        KIND_POL = 2'd2,
        KIND_CFG = 2'd3
    } reg_kind_e;

endpackage

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         rd_hit,
    input  reg_kind_e    kind,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] out_val,
    output logic [W-1:0] pol_val,
    output logic [W-1:0] cfg_val,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] diff
);

    typedef struct packed {
        logic [W-1:0] in_r;
        logic [W-1:0] out_r;
        logic [W-1:0] pol_r;
        logic [W-1:0] cfg_r;
    } port_state_t;

    port_state_t s_d, s_q;
    logic        cap;

    always_comb begin
        s_d = s_q;
        cap = rd_hit && (kind == KIND_IN);
        if (cap) begin
            s_d.in_r = pin_in;
        end
        if (wr_hit) begin
            case (kind)
                KIND_OUT: s_d.out_r = wdata;
                KIND_POL: s_d.pol_r = wdata;
                KIND_CFG: s_d.cfg_r = wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.in_r  <= '1;
            s_q.out_r <= '1;
            s_q.pol_r <= '0;
            s_q.cfg_r <= '1;
        end else begin
            s_q <= s_d;
        end
    end

    assign out_val = s_q.out_r;
    assign pol_val = s_q.pol_r;
    assign cfg_val = s_q.cfg_r;
    assign pin_out = s_q.out_r;
    assign pin_oe  = ~s_q.cfg_r;
    assign diff    = (pin_in ^ s_q.in_r) & s_q.cfg_r;

    assert_wr_input_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == KIND_IN && !rd_hit) |=> $stable(s_q.in_r));

    assert_cfg_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && kind == KIND_CFG) |=> (s_q.cfg_r == $past(wdata)));

    assert_capture_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && kind == KIND_IN) |=> (s_q.in_r == $past(pin_in)));

endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_bank_pkg::*;
#(
    parameter int W     = 8,
    parameter int PORTS = 2,
    localparam int SEL_W = $clog2(PORTS)
) (
    input  reg_kind_e                  kind,
    input  logic [SEL_W-1:0]           port_sel,
    input  logic [PORTS-1:0][W-1:0]    pins,
    input  logic [PORTS-1:0][W-1:0]    outs,
    input  logic [PORTS-1:0][W-1:0]    pols,
    input  logic [PORTS-1:0][W-1:0]    cfgs,
    output logic [W-1:0]               rd_val
);

    always_comb begin
        rd_val = '0;
        case (kind)
            KIND_IN:  rd_val = pins[port_sel] ^ pols[port_sel];
            KIND_OUT: rd_val = outs[port_sel];
            KIND_POL: rd_val = pols[port_sel];
            KIND_CFG: rd_val = cfgs[port_sel];
            default:  rd_val = '0;
        endcase
    end

endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
    parameter int W     = 8,
    parameter int PORTS = 2
) (
    input  logic [PORTS-1:0][W-1:0] diff,
    output logic                    irq_n
);

    logic [PORTS-1:0] port_pend;

    for (genvar p = 0; p < PORTS; p++) begin : g_pend
        assign port_pend[p] = |diff[p];
    end

    assign irq_n = ~(|port_pend);

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int  PORT_W = 8,
    parameter int  PORTS  = 2,
    localparam int SEL_W  = $clog2(PORTS),
    localparam int IDX_W  = SEL_W + 2,
    localparam int PINS   = PORT_W * PORTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic              wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PINS-1:0]   pin_in,
    output logic [PINS-1:0]   pin_out,
    output logic [PINS-1:0]   pin_oe,
    output logic              irq_n
);

    typedef struct packed {
        logic [PORT_W-1:0] rdata;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [SEL_W-1:0]               port_sel;
    reg_kind_e                      kind;
    logic [PORTS-1:0][PORT_W-1:0]   pins_a, outs_a, pols_a, cfgs_a, diff_a, pout_a, poe_a;
    logic [PORT_W-1:0]              rd_val;

    assign port_sel = reg_idx[SEL_W-1:0];
    assign kind     = reg_kind_e'(reg_idx[IDX_W-1:SEL_W]);

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        logic wr_hit, rd_hit;
        assign wr_hit    = wr_en && (port_sel == SEL_W'(p));
        assign rd_hit    = rd_en && (port_sel == SEL_W'(p));
        assign pins_a[p] = pin_in[p*PORT_W +: PORT_W];

        gpio_port #(.W(PORT_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hit  (wr_hit),
            .rd_hit  (rd_hit),
            .kind    (kind),
            .wdata   (wr_data),
            .pin_in  (pins_a[p]),
            .out_val (outs_a[p]),
            .pol_val (pols_a[p]),
            .cfg_val (cfgs_a[p]),
            .pin_out (pout_a[p]),
            .pin_oe  (poe_a[p]),
            .diff    (diff_a[p])
        );

        assign pin_out[p*PORT_W +: PORT_W] = pout_a[p];
        assign pin_oe[p*PORT_W +: PORT_W]  = poe_a[p];
    end

    gpio_rd_mux #(.W(PORT_W), .PORTS(PORTS)) u_mux (
        .kind     (kind),
        .port_sel (port_sel),
        .pins     (pins_a),
        .outs     (outs_a),
        .pols     (pols_a),
        .cfgs     (cfgs_a),
        .rd_val   (rd_val)
    );

    gpio_irq #(.W(PORT_W), .PORTS(PORTS)) u_irq (
        .diff  (diff_a),
        .irq_n (irq_n)
    );

    always_comb begin
        s_d = s_q;
        if (rd_en) begin
            s_d.rdata = rd_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.rdata <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.rdata;

    assert_rd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    assert_out_pins_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe == '1) |-> irq_n);

endmodule

// File: tb/gpio_bank_test.sv
module gpio_bank_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  reg_idx;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic        rd_en;
    logic [7:0]  rd_data;
    logic [15:0] pin_in;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic        irq_n;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_bank uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .reg_idx (reg_idx),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_data (rd_data),
        .pin_in  (pin_in),
        .pin_out (pin_out),
        .pin_oe  (pin_oe),
        .irq_n   (irq_n)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0] m_out [2];
    logic [7:0] m_pol [2];
    logic [7:0] m_cfg [2];
    logic [7:0] m_in  [2];

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_rd(input int idx);
        int p = idx % 2;
        case (idx / 2)
            0:       return pin_in[p*8 +: 8] ^ m_pol[p];
            1:       return m_out[p];
            2:       return m_pol[p];
            default: return m_cfg[p];
        endcase
    endfunction

    task automatic wr(input int idx, input logic [7:0] data);
        @(negedge clk);
        reg_idx = 3'(idx); wr_data = data; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        case (idx / 2)
            1: m_out[idx % 2] = data;
            2: m_pol[idx % 2] = data;
            3: m_cfg[idx % 2] = data;
            default: ;
        endcase
    endtask

    task automatic rd_chk(input int idx, input string req);
        logic [7:0] e;
        e = exp_rd(idx);
        @(negedge clk);
        reg_idx = 3'(idx); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        if (idx < 2) m_in[idx] = pin_in[idx*8 +: 8];
        chk(req, {8'h00, rd_data}, {8'h00, e});
    endtask

    task automatic irq_chk(input string req);
        logic e;
        #1;
        e = ~|((pin_in ^ {m_in[1], m_in[0]}) & {m_cfg[1], m_cfg[0]});
        chk(req, {15'd0, irq_n}, {15'd0, e});
    endtask

    task automatic pads_chk(input string req_oe, input string req_out);
        chk(req_oe, pin_oe, ~{m_cfg[1], m_cfg[0]});
        chk(req_out, pin_out, {m_out[1], m_out[0]});
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pin_in = v;
    endtask

    task automatic summary;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] hold;
        rst_n = 1'b0; reg_idx = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
        pin_in = 16'hFFFF;
        for (int p = 0; p < 2; p++) begin
            m_out[p] = 8'hFF; m_pol[p] = 8'h00; m_cfg[p] = 8'hFF; m_in[p] = 8'hFF;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        chk("R1 pin_oe", pin_oe, 16'h0000);
        chk("R1 irq_n", {15'd0, irq_n}, 16'd1);
        for (int i = 2; i < 8; i++) rd_chk(i, "R1 reset read");
        irq_chk("R1 irq after reads");

        // R2 R3 R4 write sweep over every writable index
        for (int i = 2; i < 8; i++) begin
            for (int k = 0; k < 8; k++) begin
                wr(i, 8'(k * 37 + 5 + i));
                pads_chk("R3 pin_oe", "R4 pin_out");
                for (int j = 2; j < 8; j++) rd_chk(j, "R2 readback");
            end
        end

        // R5 invert sweep, all port 0 pin values
        wr(6, 8'hFF); wr(7, 8'hFF);
        for (int v = 0; v < 256; v++) begin
            wr(4, 8'(v) ^ 8'h5A);
            wr(5, 8'(v * 3));
            set_pins({~8'(v), 8'(v)});
            rd_chk(0, "R5 port0 inverted read");
            rd_chk(1, "R5 port1 inverted read");
            if (v % 16 == 0) irq_chk("R8 both captured");
        end
        wr(4, 8'h00); wr(5, 8'h00);

        // R7 R8 change flag
        rd_chk(0, "R8 capture0"); rd_chk(1, "R8 capture1");
        irq_chk("R7 idle");
        set_pins(pin_in ^ 16'h0008);
        irq_chk("R7 port0 change");
        chk("R7 low", {15'd0, irq_n}, 16'd0);
        rd_chk(1, "R8 other port read");
        irq_chk("R8 other port keeps flag");
        rd_chk(0, "R8 own port read");
        irq_chk("R8 cleared");
        chk("R8 high", {15'd0, irq_n}, 16'd1);
        set_pins(pin_in ^ 16'h4000);
        irq_chk("R7 port1 change");
        rd_chk(1, "R8 port1 capture");
        irq_chk("R8 port1 cleared");

        // R9 output pins never flag
        wr(6, 8'hF0); wr(7, 8'h0F);
        for (int t = 0; t < 16; t++) begin
            set_pins(pin_in ^ {4'(t), 8'h00, 4'(t)});
            irq_chk("R9 output pin toggle");
        end
        set_pins(pin_in ^ 16'h0040);
        irq_chk("R7 input pin with mixed dirs");
        rd_chk(0, "R8 recapture"); rd_chk(1, "R8 recapture");
        wr(6, 8'hFF); wr(7, 8'hFF);
        rd_chk(0, "R8 recapture all"); rd_chk(1, "R8 recapture all");

        // R6 writes to input indices ignored
        wr(0, ~pin_in[7:0]);
        wr(1, ~pin_in[15:8]);
        irq_chk("R6 input write ignored");
        chk("R6 high", {15'd0, irq_n}, 16'd1);
        set_pins(pin_in ^ 16'h0101);
        irq_chk("R6 flag follows pins");
        rd_chk(0, "R6 read0"); rd_chk(1, "R6 read1");
        for (int j = 2; j < 8; j++) rd_chk(j, "R6 no register touched");

        // R10 rd_data holds without read strobe
        rd_chk(3, "R10 setup");
        hold = rd_data;
        wr(3, 8'h3C); wr(6, 8'h81); wr(0, 8'h00);
        chk("R10 hold", {8'h00, rd_data}, {8'h00, hold});
        repeat (3) @(negedge clk);
        chk("R10 hold idle", {8'h00, rd_data}, {8'h00, hold});
        pads_chk("R3 final", "R4 final");

        summary();
        $finish;
    end

endmodule